// File: doc/BRIEF.md
# PCI Master Write Staging FIFO

This block sits between user logic and the master side of a PCI-style bus controller. It collects the data for one bus-master write burst before that burst is started. User logic runs on its own clock and pushes 64-bit words with an active-low write strobe. An active-low end marker goes with the final word of the burst. The block holds up to 16 words. It reports, in the user clock domain, when it is full and when it is nearly full.

On the bus clock side, a hold input keeps the bus request low so that user logic can fill the buffer first. The request is raised when the hold is released with data waiting, or when the buffer fills, whichever happens first. Once raised, the request stays high while the words are drained through a valid/ready stream. When the word carrying the end marker is accepted, the request drops and a one-cycle completion pulse is given.

Back-pressure rules on the drain stream work as follows. `rd_valid` is only high while `bus_req` is high and a word is present. While `rd_valid` is high and `rd_ready` is low, the word and its end flag do not change. A word leaves the buffer on every bus clock edge where both `rd_valid` and `rd_ready` are high. The write side has no ready signal: user logic must watch `full_n`, and the block drops any write made while `full_n` is low.

Top module: `mwr_stage_fifo`

## Requirements
- R1: A 64-bit word is stored only on a `wclk` edge where `wr_en_n` is 0. Stored words come out on `rd_data` in the order they were written, and `wr_data` has no effect while `wr_en_n` is 1.
- R2: A write made while `full_n` is 0 is discarded. The stored contents and their order are unchanged.
- R3: `full_n` is 0 exactly when the write side sees 16 words held.
- R4: `afull_n` is 0 whenever four or fewer of the 16 slots are free as seen from the write side. This means from the 12th held word upward when nothing is being drained.
- R5: While `xfer_hold` is 1 and the bus side has not seen the buffer full, `bus_req` is not raised.
- R6: `bus_req` rises once data is present and either `xfer_hold` is 0 or the bus side sees 16 words held. The second case applies even while `xfer_hold` stays 1.
- R7: `rd_valid` is 1 only while `bus_req` is 1 and a word is present. While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid`, `rd_data` and `rd_last` hold their values.
- R8: `rd_last` is 1 on exactly the word that was written with `wr_last_n` at 0.
- R9: On the `bclk` edge that accepts the word with `rd_last` at 1, `bus_req` falls and `burst_done` rises for one `bclk` cycle. `bus_req` stays 1 across accepted words without the end flag.
- R10: After reset, `full_n` and `afull_n` are 1, and `bus_req`, `rd_valid` and `burst_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | User-side clock |
| wrst_n | input | 1 | User-side reset, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_last_n | input | 1 | End-of-burst marker for the word being written, active low |
| wr_data | input | 64 | Word to store |
| full_n | output | 1 | Buffer full, active low |
| afull_n | output | 1 | Four or fewer slots free, active low |
| bclk | input | 1 | Bus-side clock |
| brst_n | input | 1 | Bus-side reset, active low |
| xfer_hold | input | 1 | Holds off the bus request while 1 |
| bus_req | output | 1 | Bus request for the write burst |
| rd_valid | output | 1 | Drain stream word available |
| rd_ready | input | 1 | Drain stream consumer ready |
| rd_data | output | 64 | Drain stream word |
| rd_last | output | 1 | Drain stream word carries the end marker |
| burst_done | output | 1 | One-cycle pulse after the end-marked word is accepted |

## Verification
A wrong write pointer or a wrong synchronized read pointer shows up at the flags on the very next user clock. For example, `afull_n` would fall one word early or late in a fill sweep, or `full_n` would not fall on the 16th word. A dropped or doubled write does not show until the drain: the words come out shifted or repeated. A bad bus-side request state shows within a few bus clocks. Either `bus_req` rises while hold is still applied, or it stays low after the pointer synchronizers have settled. An end-flag bit lost in storage shows only at the end of a burst, as a `bus_req` that never falls and a missing `burst_done`.

// File: rtl/mwr_stage_pkg.sv
package mwr_stage_pkg;

  typedef enum logic {
    RQ_IDLE   = 1'b0,
    RQ_ACTIVE = 1'b1
  } req_state_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    b = b ^ (b >> 1);
    b = b ^ (b >> 2);
    b = b ^ (b >> 4);
    b = b ^ (b >> 8);
    b = b ^ (b >> 16);
    return b;
  endfunction

endpackage

// File: rtl/mwr_gray_sync.sv
module mwr_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/mwr_wr_ctl.sv
module mwr_wr_ctl
  import mwr_stage_pkg::*;
#(
  parameter int AW         = 4,
  parameter int AFULL_FREE = 4
) (
  input  logic        wclk,
  input  logic        wrst_n,
  input  logic        wr_en_n,
  input  logic [AW:0] rgray_sync,
  output logic [AW:0] wgray,
  output logic [AW-1:0] wr_addr,
  output logic        push,
  output logic        full_n,
  output logic        afull_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_LVL  = PW'(DEPTH);
  localparam logic [AW:0] AFULL_LVL = PW'(DEPTH - AFULL_FREE);

  logic [AW:0] wbin_q, wgray_q, rbin, used, wnext;
  logic        full;

  assign rbin  = PW'(gray2bin(32'(rgray_sync)));
  assign used  = wbin_q - rbin;
  assign full  = (used == FULL_LVL);
  assign push  = !wr_en_n && !full;
  assign wnext = wbin_q + PW'(1);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wbin_q  <= wnext;
      wgray_q <= PW'(bin2gray(32'(wnext)));
    end
  end

  assign wgray   = wgray_q;
  assign wr_addr = wbin_q[AW-1:0];
  assign full_n  = !full;
  assign afull_n = !(used >= AFULL_LVL);
endmodule

// File: rtl/mwr_rd_ctl.sv
module mwr_rd_ctl
  import mwr_stage_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          bclk,
  input  logic          brst_n,
  input  logic          xfer_hold,
  input  logic [AW:0]   wgray_sync,
  input  logic          head_last,
  input  logic          rd_ready,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] rd_addr,
  output logic          full_seen,
  output logic          rd_valid,
  output logic          bus_req,
  output logic          burst_done
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_LVL = PW'(DEPTH);

  req_state_e  state_q;
  logic [AW:0] rbin_q, rgray_q, wbin, used, rnext;
  logic        empty, pop, start, done_q;

  assign wbin      = PW'(gray2bin(32'(wgray_sync)));
  assign used      = wbin - rbin_q;
  assign empty     = (used == '0);
  assign full_seen = (used == FULL_LVL);
  assign start     = (state_q == RQ_IDLE) && !empty && (!xfer_hold || full_seen);
  assign rd_valid  = (state_q == RQ_ACTIVE) && !empty;
  assign pop       = rd_valid && rd_ready;
  assign rnext     = rbin_q + PW'(1);

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (pop) begin
      rbin_q  <= rnext;
      rgray_q <= PW'(bin2gray(32'(rnext)));
    end
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      state_q <= RQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= pop && head_last;
      if (pop && head_last) state_q <= RQ_IDLE;
      else if (start)       state_q <= RQ_ACTIVE;
    end
  end

  assign rgray      = rgray_q;
  assign rd_addr    = rbin_q[AW-1:0];
  assign bus_req    = (state_q == RQ_ACTIVE);
  assign burst_done = done_q;
endmodule

// File: rtl/mwr_stage_fifo.sv
module mwr_stage_fifo #(
  parameter int DATA_W     = 64,
  parameter int AW         = 4,
  parameter int AFULL_FREE = 4
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en_n,
  input  logic              wr_last_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full_n,
  output logic              afull_n,
  input  logic              bclk,
  input  logic              brst_n,
  input  logic              xfer_hold,
  output logic              bus_req,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              burst_done
);
  localparam int DEPTH = 1 << AW;
  localparam int EW    = DATA_W + 1;

  logic [EW-1:0] store [DEPTH];
  logic [AW:0]   wgray, wgray_b, rgray, rgray_w;
  logic [AW-1:0] wr_addr, rd_addr;
  logic          push, full_seen;
  logic [EW-1:0] head;

  mwr_wr_ctl #(.AW(AW), .AFULL_FREE(AFULL_FREE)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en_n(wr_en_n), .rgray_sync(rgray_w),
    .wgray(wgray), .wr_addr(wr_addr), .push(push),
    .full_n(full_n), .afull_n(afull_n)
  );

  mwr_gray_sync #(.W(AW + 1)) u_w2b (
    .clk(bclk), .rst_n(brst_n), .d(wgray), .q(wgray_b)
  );

  mwr_gray_sync #(.W(AW + 1)) u_b2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w)
  );

  always_ff @(posedge wclk) begin
    if (push) store[wr_addr] <= {!wr_last_n, wr_data};
  end

  assign head    = store[rd_addr];
  assign rd_data = head[DATA_W-1:0];
  assign rd_last = head[DATA_W];

  mwr_rd_ctl #(.AW(AW)) u_rd (
    .bclk(bclk), .brst_n(brst_n), .xfer_hold(xfer_hold),
    .wgray_sync(wgray_b), .head_last(head[DATA_W]), .rd_ready(rd_ready),
    .rgray(rgray), .rd_addr(rd_addr), .full_seen(full_seen),
    .rd_valid(rd_valid), .bus_req(bus_req), .burst_done(burst_done)
  );
endmodule

// File: rtl/mwr_stage_fifo_chk.sv
module mwr_stage_fifo_chk #(
  parameter int DATA_W = 64,
  parameter int AW     = 4
) (
  input logic              wclk,
  input logic              wrst_n,
  input logic              wr_en_n,
  input logic              full_n,
  input logic              afull_n,
  input logic [AW-1:0]     wr_addr,
  input logic              bclk,
  input logic              brst_n,
  input logic              xfer_hold,
  input logic              full_seen,
  input logic              bus_req,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_last,
  input logic              burst_done
);
  // R2: a refused write leaves the write address untouched
  a_r2_drop_when_full: assert property (@(posedge wclk) disable iff (!wrst_n)
    (!full_n && !wr_en_n) |=> $stable(wr_addr));

  // R4: nearly-full is always active when full is active
  a_r4_afull_covers_full: assert property (@(posedge wclk) disable iff (!wrst_n)
    !full_n |-> !afull_n);

  // R5: hold keeps the request low until the bus side sees full
  a_r5_hold_blocks_req: assert property (@(posedge bclk) disable iff (!brst_n)
    (xfer_hold && !bus_req && !full_seen) |=> !bus_req);

  // R7: no word offered without the request
  a_r7_valid_needs_req: assert property (@(posedge bclk) disable iff (!brst_n)
    rd_valid |-> bus_req);

  // R7: stalled word is held
  a_r7_stall_stable: assert property (@(posedge bclk) disable iff (!brst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

  // R9: request falls after the end-marked word is taken
  a_r9_req_drops: assert property (@(posedge bclk) disable iff (!brst_n)
    (rd_valid && rd_ready && rd_last) |=> (!bus_req && burst_done));

  // R9: completion only follows an accepted end-marked word
  a_r9_done_after_last: assert property (@(posedge bclk) disable iff (!brst_n)
    burst_done |-> $past(rd_valid && rd_ready && rd_last));
endmodule

bind mwr_stage_fifo mwr_stage_fifo_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .wr_en_n(wr_en_n), .full_n(full_n),
  .afull_n(afull_n), .wr_addr(wr_addr), .bclk(bclk), .brst_n(brst_n),
  .xfer_hold(xfer_hold), .full_seen(full_seen), .bus_req(bus_req),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .rd_last(rd_last), .burst_done(burst_done)
);

// File: tb/mwr_stage_fifo_test.sv
module mwr_stage_fifo_test;
  logic        wclk = 1'b0, bclk = 1'b0;
  logic        wrst_n = 1'b0, brst_n = 1'b0;
  logic        wr_en_n = 1'b1, wr_last_n = 1'b1;
  logic [63:0] wr_data = '0;
  logic        xfer_hold = 1'b0, rd_ready = 1'b0;
  logic        full_n, afull_n, bus_req, rd_valid, rd_last, burst_done;
  logic [63:0] rd_data;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 wclk = ~wclk;
  always #3.5 bclk = ~bclk;

  mwr_stage_fifo uut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en_n(wr_en_n), .wr_last_n(wr_last_n),
    .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n),
    .bclk(bclk), .brst_n(brst_n), .xfer_hold(xfer_hold), .bus_req(bus_req),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_last(rd_last), .burst_done(burst_done)
  );

  function automatic logic [63:0] pat(input int b, input int i);
    return {32'(b * 977 + 5), 32'(i * 313 + 1)} ^ 64'hA5C3_0F1E_96B4_7D28;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a wclk falling edge; returns at the next one
  task automatic put(input logic [63:0] d, input bit last);
    wr_en_n = 1'b0; wr_last_n = !last; wr_data = d;
    @(negedge wclk);
    wr_en_n = 1'b1; wr_last_n = 1'b1; wr_data = ~d;
  endtask

  task automatic take(input logic [63:0] exp_d, input bit exp_l, input bit stall);
    int n = 0;
    @(negedge bclk);
    while (!rd_valid && n < 400) begin @(negedge bclk); n++; end
    if (n >= 400) check("R7 word never offered", 64'(rd_valid), 64'd1);
    if (stall) begin
      repeat (2) @(negedge bclk);
      check("R7 valid held under stall", 64'(rd_valid), 64'd1);
      check("R7 data held under stall", rd_data, exp_d);
    end
    check("R1 drained word", rd_data, exp_d);
    check("R8 end flag", 64'(rd_last), 64'(exp_l));
    rd_ready = 1'b1;
    @(negedge bclk);
    rd_ready = 1'b0;
    if (exp_l) begin
      check("R9 request dropped", 64'(bus_req), 64'd0);
      check("R9 done pulse", 64'(burst_done), 64'd1);
      @(negedge bclk);
      check("R9 done single cycle", 64'(burst_done), 64'd0);
    end else begin
      check("R9 request kept mid burst", 64'(bus_req), 64'd1);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge wclk);
    wrst_n = 1'b1; brst_n = 1'b1;
    @(negedge wclk);
    // R10
    check("R10 full_n", 64'(full_n), 64'd1);
    check("R10 afull_n", 64'(afull_n), 64'd1);
    check("R10 bus_req", 64'(bus_req), 64'd0);
    check("R10 rd_valid", 64'(rd_valid), 64'd0);
    check("R10 burst_done", 64'(burst_done), 64'd0);

    // held start, then release
    @(negedge bclk); xfer_hold = 1'b1;
    @(negedge wclk);
    for (int i = 0; i < 3; i++) put(pat(1, i), 1'b0);
    repeat (20) @(negedge bclk);
    check("R5 held request", 64'(bus_req), 64'd0);
    check("R4 afull_n at 3 held", 64'(afull_n), 64'd1);
    xfer_hold = 1'b0;
    repeat (2) @(negedge bclk);
    check("R6 request after release", 64'(bus_req), 64'd1);
    check("R7 valid with request", 64'(rd_valid), 64'd1);
    @(negedge wclk);
    for (int i = 3; i < 5; i++) put(pat(1, i), i == 4);
    for (int i = 0; i < 5; i++) take(pat(1, i), i == 4, (i % 2) == 0);
    repeat (10) @(negedge bclk);
    check("R6 no request when empty", 64'(bus_req), 64'd0);

    // fill sweep with hold applied
    xfer_hold = 1'b1;
    repeat (10) @(negedge wclk);
    for (int k = 1; k <= 16; k++) begin
      put(pat(2, k), 1'b0);
      check("R3 full_n sweep", 64'(full_n), 64'(k != 16));
      check("R4 afull_n sweep", 64'(afull_n), 64'(16 - k > 4));
      if (k == 15) begin
        repeat (10) @(negedge bclk);
        check("R5 held at 15 words", 64'(bus_req), 64'd0);
        @(negedge wclk);
      end
    end
    put(64'hDEAD_BEEF_0BAD_F00D, 1'b0);
    check("R2 still full after refused write", 64'(full_n), 64'd0);
    repeat (10) @(negedge bclk);
    check("R6 request on full under hold", 64'(bus_req), 64'd1);
    for (int k = 1; k <= 16; k++) take(pat(2, k), 1'b0, (k % 5) == 0);
    check("R2 nothing after refused write", 64'(rd_valid), 64'd0);
    xfer_hold = 1'b0;
    @(negedge wclk);
    put(pat(2, 99), 1'b1);
    take(pat(2, 99), 1'b1, 1'b0);

    // burst-length sweep
    for (int n = 1; n <= 8; n++) begin
      repeat (10) @(negedge wclk);
      for (int i = 0; i < n; i++) put(pat(10 + n, i), i == n - 1);
      for (int i = 0; i < n; i++) take(pat(10 + n, i), i == n - 1, (i % 3) == 1);
    end
    repeat (10) @(negedge wclk);
    check("R3 full_n after drains", 64'(full_n), 64'd1);
    check("R4 afull_n after drains", 64'(afull_n), 64'd1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule